// File: doc/BRIEF.md
# Codec Immediate Command Port

This block gives host software a direct path for exchanging a single 32-bit command word with an audio codec and collecting the one 32-bit reply. It does this without any DMA ring buffers. Three host-visible registers are provided: a command word, a read-only response word and a 16-bit status word. Software loads the command, launches it by writing 1 to the busy bit, and polls the status until it shows busy clear and response valid.

On the link side, the block presents the command word together with a one-cycle valid strobe. The same word is also split into its fields: codec address, node, 12-bit command and 8-bit payload. The link layer returns the reply with its own valid strobe. The block captures that reply, drops busy and raises response-valid on the same clock edge.

Top module: `codec_imm_port`

## Requirements
- R1: After reset, reads of the command (60h), response (64h) and status (68h) registers return zero, and `cmd_valid_o` is low.
- R2: While the port is idle, a write to 60h loads the command word, and a read of 60h returns it.
- R3: Writing status with bit 0 = 1 while idle sets busy, so a status read returns 01b in bits 1:0. In the clock cycle after that write, `cmd_valid_o` is high for exactly one cycle, and `cmd_word_o` carries the stored command.
- R4: The command fields are decoded as follows: codec address = bits 31:28, node = bits 27:20, command = bits 19:8, payload = bits 7:0. For example, 11571C11h gives 1, 15h, 71Ch and 11h.
- R5: When `rsp_valid_i` is high while busy, the response register loads `rsp_word_i`. On that same edge busy clears and response-valid (status bit 1) sets, so status bits 1:0 read 10b.
- R6: Writing 1 to status bit 1 clears response-valid. Writing 0 to it leaves the flag unchanged.
- R7: Writes to 60h while busy is set are ignored.
- R8: Writing 1 to bit 0 while already busy has no effect, and in particular produces no second strobe.
- R9: Launching a command while response-valid is set clears response-valid. Busy and response-valid are never set together.
- R10: A `rsp_valid_i` pulse while idle is ignored: both the response register and the status stay unchanged.
- R11: Writes to 64h do not change the response register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| cmd_valid_o | output | 1 | One-cycle command strobe |
| cmd_word_o | output | 32 | Command word to the link |
| cmd_cad_o | output | 4 | Codec address field |
| cmd_node_o | output | 8 | Node field |
| cmd_verb_o | output | 12 | Command field |
| cmd_payload_o | output | 8 | Payload field |
| rsp_valid_i | input | 1 | Response strobe from the link |
| rsp_word_i | input | 32 | Response word |

## Verification
Several command words are launched: 11571C11h, a word with every field distinct, and a word with all upper field bits set. Each is compared with the scoreboard. Any swap or misplacement of field boundaries therefore shows up in the decoded outputs. Stimulus that must be rejected is also applied: command writes and re-launches while busy, responses while idle, and writes to the response register. These separate the correct gating from a block that lets such stimulus through. The status value is read after each step, which exposes the ordering of busy and response-valid, including the automatic clear on relaunch and the write-one-to-clear behaviour.

// File: rtl/codec_imm_pkg.sv
package codec_imm_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned STAT_W = 16;

  localparam logic [ADDR_W-1:0] OFS_CMD  = 8'h60;
  localparam logic [ADDR_W-1:0] OFS_RSP  = 8'h64;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h68;

  localparam int unsigned BIT_BUSY = 0;
  localparam int unsigned BIT_RVLD = 1;

  typedef struct packed {
    logic [3:0]  cad;
    logic [7:0]  node;
    logic [11:0] verb;
    logic [7:0]  payload;
  } cmd_fields_t;
endpackage

// File: rtl/codec_imm_regs.sv
module codec_imm_regs
  import codec_imm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              busy_i,
  input  logic              rvld_i,
  input  logic              cap_i,
  input  logic [WORD_W-1:0] rsp_word_i,
  output logic [WORD_W-1:0] cmd_q_o,
  output logic [WORD_W-1:0] rsp_q_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic              launch_req_o,
  output logic              clr_req_o
);
  localparam int unsigned PAD_W = WORD_W - STAT_W;

  logic [WORD_W-1:0] cmd_q, rsp_q;
  logic [STAT_W-1:0] stat_view;
  logic              stat_wr;

  assign stat_wr = wr_i && (addr_i == OFS_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
    end else if (wr_i && (addr_i == OFS_CMD) && !busy_i) begin
      cmd_q <= wdata_i;
    end
  end

  // response register only loads from the link
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_q <= '0;
    end else if (cap_i) begin
      rsp_q <= rsp_word_i;
    end
  end

  always_comb begin
    stat_view           = '0;
    stat_view[BIT_BUSY] = busy_i;
    stat_view[BIT_RVLD] = rvld_i;
  end

  always_comb begin
    unique case (addr_i)
      OFS_CMD:  rdata_o = cmd_q;
      OFS_RSP:  rdata_o = rsp_q;
      OFS_STAT: rdata_o = {{PAD_W{1'b0}}, stat_view};
      default:  rdata_o = '0;
    endcase
  end

  assign launch_req_o = stat_wr && wdata_i[BIT_BUSY];
  assign clr_req_o    = stat_wr && wdata_i[BIT_RVLD];
  assign cmd_q_o      = cmd_q;
  assign rsp_q_o      = rsp_q;
endmodule

// File: rtl/codec_imm_ctrl.sv
module codec_imm_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic launch_req_i,
  input  logic clr_req_i,
  input  logic rsp_valid_i,
  output logic busy_o,
  output logic rvld_o,
  output logic issue_o,
  output logic cap_o
);
  logic busy_q, rvld_q, issue_q;
  logic launch;

  assign launch = launch_req_i && !busy_q;
  assign cap_o  = rsp_valid_i && busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      rvld_q  <= 1'b0;
      issue_q <= 1'b0;
    end else begin
      issue_q <= launch;
      if (launch) begin
        busy_q <= 1'b1;
        rvld_q <= 1'b0;  // stale reply never reported
      end else if (cap_o) begin
        busy_q <= 1'b0;
        rvld_q <= 1'b1;
      end else if (clr_req_i) begin
        rvld_q <= 1'b0;
      end
    end
  end

  assign busy_o  = busy_q;
  assign rvld_o  = rvld_q;
  assign issue_o = issue_q;
endmodule

// File: rtl/codec_imm_fields.sv
module codec_imm_fields
  import codec_imm_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output logic [3:0]        cad_o,
  output logic [7:0]        node_o,
  output logic [11:0]       verb_o,
  output logic [7:0]        payload_o
);
  cmd_fields_t f;
  assign f         = cmd_fields_t'(word_i);
  assign cad_o     = f.cad;
  assign node_o    = f.node;
  assign verb_o    = f.verb;
  assign payload_o = f.payload;
endmodule

// File: rtl/codec_imm_port.sv
module codec_imm_port
  import codec_imm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o,
  output logic              cmd_valid_o,
  output logic [WORD_W-1:0] cmd_word_o,
  output logic [3:0]        cmd_cad_o,
  output logic [7:0]        cmd_node_o,
  output logic [11:0]       cmd_verb_o,
  output logic [7:0]        cmd_payload_o,
  input  logic              rsp_valid_i,
  input  logic [WORD_W-1:0] rsp_word_i
);
  logic              busy, rsp_vld, cap, launch_req, clr_req, issue;
  logic [WORD_W-1:0] cmd_q, rsp_q;

  codec_imm_regs i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (reg_wr_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .busy_i      (busy),
    .rvld_i      (rsp_vld),
    .cap_i       (cap),
    .rsp_word_i  (rsp_word_i),
    .cmd_q_o     (cmd_q),
    .rsp_q_o     (rsp_q),
    .rdata_o     (reg_rdata_o),
    .launch_req_o(launch_req),
    .clr_req_o   (clr_req)
  );

  codec_imm_ctrl i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .launch_req_i(launch_req),
    .clr_req_i   (clr_req),
    .rsp_valid_i (rsp_valid_i),
    .busy_o      (busy),
    .rvld_o      (rsp_vld),
    .issue_o     (issue),
    .cap_o       (cap)
  );

  codec_imm_fields i_fields (
    .word_i   (cmd_q),
    .cad_o    (cmd_cad_o),
    .node_o   (cmd_node_o),
    .verb_o   (cmd_verb_o),
    .payload_o(cmd_payload_o)
  );

  assign cmd_valid_o = issue;
  assign cmd_word_o  = cmd_q;
endmodule

// File: rtl/codec_imm_port_chk.sv
module codec_imm_port_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        busy,
  input logic        rsp_vld,
  input logic        cmd_valid_o,
  input logic        rsp_valid_i,
  input logic [31:0] rsp_word_i,
  input logic [31:0] cmd_q,
  input logic [31:0] rsp_q
);
  assert_strobe_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> busy);

  assert_rise_strobe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> cmd_valid_o);

  assert_single_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);

  assert_capture_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && rsp_valid_i) |=> (!busy && rsp_vld && rsp_q == $past(rsp_word_i)));

  assert_cmd_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> $stable(cmd_q));

  assert_idle_rsp_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |=> $stable(rsp_q));

  assert_exclusive_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy && rsp_vld));
endmodule

bind codec_imm_port codec_imm_port_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy       (busy),
  .rsp_vld    (rsp_vld),
  .cmd_valid_o(cmd_valid_o),
  .rsp_valid_i(rsp_valid_i),
  .rsp_word_i (rsp_word_i),
  .cmd_q      (cmd_q),
  .rsp_q      (rsp_q)
);

// File: tb/test_codec_imm_port.sv
`timescale 1ns/1ps
module test_codec_imm_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cmd_valid;
  logic [31:0] cmd_word;
  logic [3:0]  cad;
  logic [7:0]  node;
  logic [11:0] verb;
  logic [7:0]  payload;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_word = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];

  always #10 clk = ~clk;

  codec_imm_port i_codec_imm_port (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata),
    .cmd_valid_o(cmd_valid), .cmd_word_o(cmd_word),
    .cmd_cad_o(cad), .cmd_node_o(node), .cmd_verb_o(verb), .cmd_payload_o(payload),
    .rsp_valid_i(rsp_valid), .rsp_word_i(rsp_word)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic respond(input logic [31:0] d);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_word = d;
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  task automatic launch(input logic [31:0] d);
    wr(8'h60, d);
    exp_q.push_back(d);
    wr(8'h68, 32'h1);
  endtask

  // scoreboard monitor: every strobe must match a queued launch
  always @(negedge clk) begin
    if (rst_n && cmd_valid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R8 actual=unexpected strobe %h expected=no strobe", cmd_word);
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        check("R3 word", cmd_word, e);
        check("R4 cad", {28'h0, cad}, {28'h0, e[31:28]});
        check("R4 node", {24'h0, node}, {24'h0, e[27:20]});
        check("R4 verb", {20'h0, verb}, {20'h0, e[19:8]});
        check("R4 payload", {24'h0, payload}, {24'h0, e[7:0]});
      end
    end
  end

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_chk("R1 cmd", 8'h60, 32'h0);
    rd_chk("R1 rsp", 8'h64, 32'h0);
    rd_chk("R1 stat", 8'h68, 32'h0);
    check("R1 strobe", {31'h0, cmd_valid}, 32'h0);

    // R2 write/readback
    wr(8'h60, 32'h1157_1C11);
    rd_chk("R2 cmd", 8'h60, 32'h1157_1C11);
    check("R4 decode 11571C11", {cad, node, verb, payload}, {4'h1, 8'h15, 12'h71C, 8'h11});

    // R3 launch
    exp_q.push_back(32'h1157_1C11);
    wr(8'h68, 32'h1);
    rd_chk("R3 busy", 8'h68, 32'h1);

    // R7 command write while busy ignored
    wr(8'h60, 32'hDEAD_BEEF);
    rd_chk("R7 cmd", 8'h60, 32'h1157_1C11);

    // R8 relaunch while busy: no strobe (monitor), status unchanged
    wr(8'h68, 32'h1);
    rd_chk("R8 stat", 8'h68, 32'h1);

    // R5 response capture
    respond(32'hAABB_CCDD);
    rd_chk("R5 rsp", 8'h64, 32'hAABB_CCDD);
    rd_chk("R5 stat", 8'h68, 32'h2);

    // R6 writing 0 leaves valid
    wr(8'h68, 32'h0);
    rd_chk("R6 keep", 8'h68, 32'h2);

    // R11 response register read-only
    wr(8'h64, 32'h1234_5678);
    rd_chk("R11 rsp", 8'h64, 32'hAABB_CCDD);

    // R10 response while idle ignored
    respond(32'h5555_5555);
    rd_chk("R10 rsp", 8'h64, 32'hAABB_CCDD);
    rd_chk("R10 stat", 8'h68, 32'h2);

    // R9 launch with valid set clears valid
    launch(32'h20A0_F005);
    rd_chk("R9 stat", 8'h68, 32'h1);
    respond(32'h0102_0304);
    rd_chk("R5 rsp2", 8'h64, 32'h0102_0304);
    rd_chk("R5 stat2", 8'h68, 32'h2);

    // R6 write-one-to-clear
    wr(8'h68, 32'h2);
    rd_chk("R6 clear", 8'h68, 32'h0);
    rd_chk("R6 rsp kept", 8'h64, 32'h0102_0304);

    // upper field bits all set
    launch(32'hFFFF_F0FF);
    respond(32'hCAFE_0001);
    rd_chk("R5 rsp3", 8'h64, 32'hCAFE_0001);
    rd_chk("R5 stat3", 8'h68, 32'h2);

    repeat (3) @(negedge clk);
    check("R3 all strobes seen", exp_q.size(), 32'h0);
    done = 1'b1;
    finish_run();
  end
endmodule